// File: doc/BRIEF.md
# Shared Peripheral Bus Arbiter

This block lets two masters share one APB-style peripheral bus. One master is a DMA engine and the other is the CPU path arriving over an AHB-to-APB bridge. Each master presents an address, a write flag and write data. The arbiter awards the bus for one transfer at a time. It drives the SETUP and ACCESS phases itself, including any PREADY wait states. When the transfer ends it returns the read data and the slave error flag to whichever master owned it.

The DMA holds a level request for as long as it has work, and each completed transfer is marked by a one-cycle done strobe. The bridge side behaves like an AHB data phase. A request is taken while `hready` is high, and `hready` then stays low until the APB transfer finishes.

When both masters contend, the DMA is normally preferred. A refusal counter records how many contended arbitrations in a row the bridge has lost. Once that count reaches `LOCK_LIMIT`, the next contended arbitration goes to the bridge, and the DMA then regains priority. With the default limit of three, the bridge receives at least one transfer out of every four contended ones.

Top module: `periph_bus_arbiter`

## Requirements
- R1: After reset, `psel`, `penable` and `dma_done` are 0, and `hready` is 1.
- R2: Every transfer starts with one SETUP cycle (`psel`=1, `penable`=0) and is followed by an ACCESS cycle (`psel`=1, `penable`=1). During these cycles `paddr`, `pwrite` and `pwdata` carry the granted master's values.
- R3: The ACCESS phase lasts until `pready` is 1, which takes wait count + 1 cycles. During that time the address, control and data stay stable, and the bus is not handed to the other master.
- R4: When the DMA requests and a bridge request is pending at the same arbitration, the DMA wins, provided the refusal count is below `LOCK_LIMIT`.
- R5: Each contended arbitration the bridge loses raises the refusal count by one, and the count saturates at `LOCK_LIMIT` (default 3). Suppose the DMA requests continuously and a bridge request is accepted while a DMA transfer is in flight. Then exactly `LOCK_LIMIT` further DMA transfers run before the bridge transfer.
- R6: The refusal count is cleared when the bridge is granted and whenever no bridge request is pending. After the bridge transfer, the next arbitration against a DMA request goes to the DMA.
- R7: An uncontended request is granted at the first idle arbitration. A DMA request raised during an idle cycle c produces SETUP in cycle c+1. A bridge request accepted in cycle c produces SETUP in cycle c+2.
- R8: A bridge request is accepted in a cycle where `br_req` and `hready` are both 1. `hready` is 0 from the next cycle until the completing ACCESS cycle. It returns to 1 in the following cycle, and `br_rdata`/`br_slverr` then hold the `prdata`/`pslverr` sampled at completion.
- R9: A DMA transfer ends with `dma_done`=1 for exactly one cycle, namely the cycle after the completing ACCESS cycle. In that cycle `dma_rdata`/`dma_slverr` hold the sampled `prdata`/`pslverr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | 1 | DMA level request, held while more transfers are wanted |
| dma_addr | input | ADDR_W | DMA transfer address |
| dma_write | input | 1 | DMA write flag |
| dma_wdata | input | DATA_W | DMA write data |
| dma_done | output | 1 | One-cycle completion strobe for the DMA |
| dma_rdata | output | DATA_W | Read data returned to the DMA |
| dma_slverr | output | 1 | Slave error returned to the DMA |
| br_req | input | 1 | Bridge request, taken while hready is 1 |
| br_addr | input | ADDR_W | Bridge transfer address |
| br_write | input | 1 | Bridge write flag |
| br_wdata | input | DATA_W | Bridge write data |
| hready | output | 1 | AHB-side ready, low while a bridge transfer is outstanding |
| br_rdata | output | DATA_W | Read data returned to the bridge |
| br_slverr | output | 1 | Slave error returned to the bridge |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (ACCESS phase) |
| paddr | output | ADDR_W | APB address |
| pwrite | output | 1 | APB write flag |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB ready, ends ACCESS |
| pslverr | input | 1 | APB slave error |

## Verification
Single transfers from each master alone, run with zero and with two wait states, separate the phase sequencing and wait-state stretching from the grant latency of each side. They also separate the DMA strobe from the bridge `hready` return.

A continuous DMA stream with a bridge request injected in the middle of a transfer shows whether the DMA wins contended arbitrations. It also shows whether reversal comes after exactly `LOCK_LIMIT` refusals. A second injection, made in the idle cycle just after the bridge transfer, shows whether the count was cleared and whether DMA priority was restored rather than left reversed. Odd addresses make the peripheral model flag a slave error, so a correct return of `pslverr` can be told apart from a stuck flag.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;

  typedef enum logic {
    OWN_DMA = 1'b0,
    OWN_BR  = 1'b1
  } owner_t;
endpackage

// File: rtl/lockout_arbiter.sv
module lockout_arbiter #(
  parameter int LOCK_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic arb_en,
  input  logic dma_req,
  input  logic br_pend,
  output logic grant_v,
  output logic grant_br
);
  localparam int CNT_W = $clog2(LOCK_LIMIT + 2);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LOCK_LIMIT);

  logic [CNT_W-1:0] refusals;
  logic             reversed;

  assign reversed = (refusals == LIMIT_C);
  assign grant_v  = arb_en & (dma_req | br_pend);
  assign grant_br = br_pend & (~dma_req | reversed);

  always_ff @(posedge clk) begin
    if (rst) begin
      refusals <= '0;
    end else if (arb_en) begin
      if (!br_pend || grant_br) begin
        refusals <= '0;
      end else if (!reversed) begin
        refusals <= refusals + 1'b1;
      end
    end
  end

  // R5: the count never passes the limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    refusals <= LIMIT_C);

  // R5: a contended loss below the limit adds exactly one refusal
  a_r5_count_loss: assert property (@(posedge clk) disable iff (rst)
    (arb_en && dma_req && br_pend && !reversed) |=> refusals == $past(refusals) + 1'b1);

  // R6: granting the bridge clears the count
  a_r6_clear_on_grant: assert property (@(posedge clk) disable iff (rst)
    (arb_en && br_pend && grant_br) |=> refusals == '0);

  // R4: below the limit, contention goes to the DMA
  a_r4_dma_first: assert property (@(posedge clk) disable iff (rst)
    (arb_en && dma_req && br_pend && refusals < LIMIT_C) |-> !grant_br);
endmodule

// File: rtl/apb_phase_fsm.sv
module apb_phase_fsm
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant_v,
  input  logic              grant_br,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic              dma_write,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              br_write,
  input  logic [DATA_W-1:0] br_wdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr,
  output logic              phase_idle,
  output logic              br_fin,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic              dma_done,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dma_slverr
);
  localparam int NSRC = 2;

  phase_t phase;
  owner_t owner;

  logic [ADDR_W-1:0] src_addr  [NSRC];
  logic              src_write [NSRC];
  logic [DATA_W-1:0] src_wdata [NSRC];
  logic [$clog2(NSRC)-1:0] sel_idx;

  assign src_addr[0]  = dma_addr;
  assign src_write[0] = dma_write;
  assign src_wdata[0] = dma_wdata;
  assign src_addr[1]  = br_addr;
  assign src_write[1] = br_write;
  assign src_wdata[1] = br_wdata;
  assign sel_idx      = grant_br;

  assign phase_idle = (phase == PH_IDLE);
  assign br_fin     = (phase == PH_ACCESS) & pready & (owner == OWN_BR);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      owner      <= OWN_DMA;
      psel       <= 1'b0;
      penable    <= 1'b0;
      paddr      <= '0;
      pwrite     <= 1'b0;
      pwdata     <= '0;
      dma_done   <= 1'b0;
      dma_rdata  <= '0;
      dma_slverr <= 1'b0;
    end else begin
      dma_done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (grant_v) begin
            phase  <= PH_SETUP;
            owner  <= grant_br ? OWN_BR : OWN_DMA;
            psel   <= 1'b1;
            paddr  <= src_addr[sel_idx];
            pwrite <= src_write[sel_idx];
            pwdata <= src_wdata[sel_idx];
          end
        end
        PH_SETUP: begin
          penable <= 1'b1;
          phase   <= PH_ACCESS;
        end
        PH_ACCESS: begin
          if (pready) begin
            psel    <= 1'b0;
            penable <= 1'b0;
            phase   <= PH_IDLE;
            if (owner == OWN_DMA) begin
              dma_done   <= 1'b1;
              dma_rdata  <= prdata;
              dma_slverr <= pslverr;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: SETUP is always followed by ACCESS
  a_r2_setup_then_access: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable));

  // R2: enable never without select
  a_r2_enable_needs_sel: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel);

  // R3: a stalled ACCESS keeps the bus steady
  a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  // R9: completion strobe lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    dma_done |=> !dma_done);
endmodule

// File: rtl/bridge_front.sv
module bridge_front #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_req,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              br_write,
  input  logic [DATA_W-1:0] br_wdata,
  input  logic              fin,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  output logic              pend,
  output logic [ADDR_W-1:0] held_addr,
  output logic              held_write,
  output logic [DATA_W-1:0] held_wdata,
  output logic              hready,
  output logic [DATA_W-1:0] br_rdata,
  output logic              br_slverr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      hready     <= 1'b1;
      held_addr  <= '0;
      held_write <= 1'b0;
      held_wdata <= '0;
      br_rdata   <= '0;
      br_slverr  <= 1'b0;
    end else if (fin) begin
      pend      <= 1'b0;
      hready    <= 1'b1;
      br_rdata  <= prdata;
      br_slverr <= pslverr;
    end else if (br_req && hready) begin
      pend       <= 1'b1;
      hready     <= 1'b0;
      held_addr  <= br_addr;
      held_write <= br_write;
      held_wdata <= br_wdata;
    end
  end

  // R8: an accepted request pulls ready low
  a_r8_low_after_accept: assert property (@(posedge clk) disable iff (rst)
    (br_req && hready) |=> !hready);

  // R8: completion releases ready
  a_r8_release_on_fin: assert property (@(posedge clk) disable iff (rst)
    fin |=> (hready && !pend));
endmodule

// File: rtl/periph_bus_arbiter.sv
module periph_bus_arbiter #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LOCK_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_req,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic              dma_write,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_done,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dma_slverr,
  input  logic              br_req,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              br_write,
  input  logic [DATA_W-1:0] br_wdata,
  output logic              hready,
  output logic [DATA_W-1:0] br_rdata,
  output logic              br_slverr,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);
  logic              br_pend;
  logic [ADDR_W-1:0] br_held_addr;
  logic              br_held_write;
  logic [DATA_W-1:0] br_held_wdata;
  logic              br_fin;
  logic              phase_idle;
  logic              grant_v;
  logic              grant_br;

  bridge_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk        (clk),
    .rst        (rst),
    .br_req     (br_req),
    .br_addr    (br_addr),
    .br_write   (br_write),
    .br_wdata   (br_wdata),
    .fin        (br_fin),
    .prdata     (prdata),
    .pslverr    (pslverr),
    .pend       (br_pend),
    .held_addr  (br_held_addr),
    .held_write (br_held_write),
    .held_wdata (br_held_wdata),
    .hready     (hready),
    .br_rdata   (br_rdata),
    .br_slverr  (br_slverr)
  );

  lockout_arbiter #(.LOCK_LIMIT(LOCK_LIMIT)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .arb_en   (phase_idle),
    .dma_req  (dma_req),
    .br_pend  (br_pend),
    .grant_v  (grant_v),
    .grant_br (grant_br)
  );

  apb_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .grant_v    (grant_v),
    .grant_br   (grant_br),
    .dma_addr   (dma_addr),
    .dma_write  (dma_write),
    .dma_wdata  (dma_wdata),
    .br_addr    (br_held_addr),
    .br_write   (br_held_write),
    .br_wdata   (br_held_wdata),
    .prdata     (prdata),
    .pready     (pready),
    .pslverr    (pslverr),
    .phase_idle (phase_idle),
    .br_fin     (br_fin),
    .psel       (psel),
    .penable    (penable),
    .paddr      (paddr),
    .pwrite     (pwrite),
    .pwdata     (pwdata),
    .dma_done   (dma_done),
    .dma_rdata  (dma_rdata),
    .dma_slverr (dma_slverr)
  );

  // R8: the bridge is never waiting with ready high while the bus serves it
  a_r8_low_while_owned: assert property (@(posedge clk) disable iff (rst)
    (br_pend && psel) |-> !hready);
endmodule

// File: tb/tb_periph_bus_arbiter.sv
module tb_periph_bus_arbiter;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LIMIT  = 3;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_req = 1'b0, dma_write = 1'b0;
  logic [ADDR_W-1:0] dma_addr = '0;
  logic [DATA_W-1:0] dma_wdata = '0;
  logic dma_done, dma_slverr;
  logic [DATA_W-1:0] dma_rdata;
  logic br_req = 1'b0, br_write = 1'b0;
  logic [ADDR_W-1:0] br_addr = '0;
  logic [DATA_W-1:0] br_wdata = '0;
  logic hready, br_slverr;
  logic [DATA_W-1:0] br_rdata;
  logic psel, penable, pwrite;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pwdata;
  logic [DATA_W-1:0] prdata = '0;
  logic pready = 1'b0, pslverr = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  int waits_cfg = 0, wcnt = 0;
  logic dma_auto = 1'b0;
  logic log_br [64];
  int n_setup = 0;

  always #10 clk = ~clk;

  periph_bus_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_write(dma_write), .dma_wdata(dma_wdata),
    .dma_done(dma_done), .dma_rdata(dma_rdata), .dma_slverr(dma_slverr),
    .br_req(br_req), .br_addr(br_addr), .br_write(br_write), .br_wdata(br_wdata),
    .hready(hready), .br_rdata(br_rdata), .br_slverr(br_slverr),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
    return {~a, a};
  endfunction

  // peripheral model and setup log, updated mid-cycle
  always @(negedge clk) begin
    if (psel && !penable) begin
      wcnt = waits_cfg;
      if (n_setup < 64) log_br[n_setup] = paddr[ADDR_W-1];
      n_setup = n_setup + 1;
      pready = 1'b0;
    end else if (psel && penable) begin
      pready = (wcnt == 0);
      if (wcnt > 0) wcnt = wcnt - 1;
    end else begin
      pready = 1'b0;
    end
    prdata  = exp_rd(paddr);
    pslverr = paddr[0];
  end

  // streaming DMA master
  always @(negedge clk) begin
    #2;
    if (dma_auto) begin
      if (dma_done) dma_addr = dma_addr + 16'd2;
      dma_req = 1'b1;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > WATCHDOG) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks = checks + 1;
    if (act !== expv) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic t_reset();
    chk("R1 psel", psel, 0);
    chk("R1 penable", penable, 0);
    chk("R1 hready", hready, 1);
    chk("R1 dma_done", dma_done, 0);
  endtask

  task automatic t_dma(input logic [ADDR_W-1:0] a, input logic wr,
                       input logic [DATA_W-1:0] wd, input int waits);
    int nacc;
    waits_cfg = waits;
    step();
    dma_req = 1'b1; dma_addr = a; dma_write = wr; dma_wdata = wd;
    step();
    chk("R7 dma setup next cycle", {psel, penable}, 2'b10);
    chk("R2 dma paddr", paddr, a);
    chk("R2 dma pwrite", pwrite, wr);
    chk("R2 dma pwdata", pwdata, wd);
    nacc = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (psel && penable) nacc++;
      if (psel && penable && pready) break;
    end
    chk("R3 dma access length", nacc, waits + 1);
    chk("R3 dma addr held", paddr, a);
    step();
    chk("R9 dma_done", dma_done, 1);
    chk("R9 dma_rdata", dma_rdata, exp_rd(a));
    chk("R9 dma_slverr", dma_slverr, a[0]);
    dma_req = 1'b0;
    step();
    chk("R9 dma_done single", dma_done, 0);
    chk("R2 bus idle after", psel, 0);
  endtask

  task automatic t_br(input logic [ADDR_W-1:0] a, input logic wr,
                      input logic [DATA_W-1:0] wd, input int waits);
    int nacc;
    waits_cfg = waits;
    step();
    chk("R8 hready idle", hready, 1);
    br_req = 1'b1; br_addr = a; br_write = wr; br_wdata = wd;
    step();
    br_req = 1'b0; br_addr = '0; br_wdata = '0;
    chk("R8 hready low after accept", hready, 0);
    chk("R7 no setup yet", psel, 0);
    step();
    chk("R7 br setup at c+2", {psel, penable}, 2'b10);
    chk("R2 br paddr", paddr, a);
    chk("R2 br pwrite", pwrite, wr);
    chk("R2 br pwdata", pwdata, wd);
    nacc = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (psel && penable) begin
        nacc++;
        chk("R8 hready low in access", hready, 0);
      end
      if (psel && penable && pready) break;
    end
    chk("R3 br access length", nacc, waits + 1);
    step();
    chk("R8 hready back", hready, 1);
    chk("R8 br_rdata", br_rdata, exp_rd(a));
    chk("R8 br_slverr", br_slverr, a[0]);
  endtask

  task automatic wait_hready();
    for (int i = 0; i < 200; i++) begin
      step();
      if (hready) break;
    end
  endtask

  task automatic t_contention();
    int base, idx0, idx1;
    waits_cfg = 1;
    dma_write = 1'b0;
    dma_addr  = 16'h0200;
    base = n_setup;
    dma_auto = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      if (n_setup > base) break;
    end
    // bridge request arrives while the first DMA transfer runs
    br_req = 1'b1; br_addr = 16'h8040; br_write = 1'b0;
    step();
    br_req = 1'b0;
    idx0 = n_setup;
    wait_hready();
    chk("R5 transfers until bridge", n_setup - idx0, LIMIT + 1);
    for (int k = 0; k < LIMIT; k++)
      chk("R4 contended grant to dma", log_br[idx0 + k], 0);
    chk("R5 bridge wins after limit", log_br[idx0 + LIMIT], 1);
    chk("R8 br_rdata in stream", br_rdata, exp_rd(16'h8040));
    // second request in the idle cycle right after the bridge transfer
    br_req = 1'b1; br_addr = 16'h8081; br_write = 1'b1; br_wdata = 32'h1234_5678;
    step();
    br_req = 1'b0;
    idx1 = n_setup;
    chk("R6 dma regains priority", log_br[idx1 - 1], 0);
    wait_hready();
    chk("R6 count restarted", n_setup - idx1, LIMIT + 1);
    chk("R5 second bridge turn", log_br[idx1 + LIMIT], 1);
    chk("R8 br_slverr in stream", br_slverr, 1);
    dma_auto = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (dma_done) begin
        dma_req = 1'b0;
        break;
      end
    end
    step();
    step();
    step();
    chk("R6 bus idle after stream", psel, 0);
  endtask

  initial begin
    step();
    step();
    rst = 1'b0;
    step();
    t_reset();
    t_dma(16'h0010, 1'b0, 32'h0, 0);
    t_dma(16'h0023, 1'b1, 32'hCAFE_0001, 2);
    t_br(16'h8100, 1'b0, 32'h0, 0);
    t_br(16'h8105, 1'b1, 32'hBEEF_0002, 2);
    t_contention();
    finish_run();
  end
endmodule